// File: doc/BRIEF.md
# USART Bit-Rate and Transfer-Clock Generator

This block sets the bit timing for a serial port that runs in one of four ways: asynchronous at normal speed, asynchronous at double speed, synchronous with the transfer clock driven out, or synchronous with the transfer clock taken from a pin. A 12-bit divider setting `S` drives a down-counter. The counter emits one single-cycle tick every `S+1` system clocks. In the asynchronous modes each tick is one receiver oversample. A transmitter bit boundary falls on every 16th tick at normal speed and on every 8th tick at double speed. In master mode each tick toggles the transfer clock, so one clock period spans two ticks. In slave mode the pin passes through a two-stage synchronizer and an edge detector, and the edges it finds replace the internal divider as the timing source.

Writing a new setting restarts the counter, the oversample phase and the generated transfer clock at once, so the new rate starts without waiting for the old period to end. Framing, shifting and data recovery are left to the transmitter and receiver that use these strobes.

Top module: `usart_rate_gen`

## Requirements
- R1: While reset is held, and after reset until the first tick, `rx_samp_en`, `tx_bit_en` and `xck_out` are low. Reset clears the counter, so the first tick follows one clock after reset is released.
- R2: With `mode` = 2'b00 and `dbl_speed` = 0, `rx_samp_en` pulses for one cycle every `S+1` clocks. `tx_bit_en` pulses every `16*(S+1)` clocks, and each of its pulses lands on a cycle where `rx_samp_en` is also high.
- R3: With `mode` = 2'b00 and `dbl_speed` = 1, `rx_samp_en` still pulses every `S+1` clocks, and `tx_bit_en` pulses every `8*(S+1)` clocks.
- R4: With `mode` = 2'b01, `xck_oe` is high and `xck_out` toggles one cycle after each tick, giving a period of `2*(S+1)` clocks. `rx_samp_en` marks the tick that raises `xck_out` and `tx_bit_en` marks the tick that lowers it.
- R5: In the synchronous modes (`mode` ≠ 2'b00), `dbl_speed` has no effect on any output.
- R6: A cycle with `div_wr` high loads `div_set` into the counter and clears the oversample phase and `xck_out`. No strobe appears in the following cycle. The first `rx_samp_en` appears `S+1` clocks after the write edge. In asynchronous mode the first `tx_bit_en` appears `16*(S+1)` clocks after the write edge (`8*(S+1)` at double speed). In master mode it appears `2*(S+1)` clocks after the write edge.
- R7: With `mode[1]` = 1 (slave), a rising level on `xck_in` produces a one-cycle `rx_samp_en` two clocks after it is first sampled. A falling level produces a one-cycle `tx_bit_en` with the same delay. One pin transition never produces both strobes.
- R8: In slave mode `xck_oe` and `xck_out` stay low, and the internal divider's ticks never appear on the strobes.
- R9: A setting of 0 gives a tick on every clock, so in asynchronous mode `rx_samp_en` stays high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_set | input | 12 | Divider setting S (0 to 4095) |
| div_wr | input | 1 | Loads div_set and restarts the timing |
| dbl_speed | input | 1 | Double-speed select, used only when asynchronous |
| mode | input | 2 | 00 asynchronous, 01 synchronous master, 1x synchronous slave |
| xck_in | input | 1 | External transfer clock pin, used in slave mode |
| xck_out | output | 1 | Generated transfer clock |
| xck_oe | output | 1 | Output enable for the transfer clock pin |
| tx_bit_en | output | 1 | Transmitter bit-clock enable strobe |
| rx_samp_en | output | 1 | Receiver sampling enable strobe |

## Verification
The hardest situation to reach is the relation between the long transmitter period and the restart caused by a write. A `tx_bit_en` appears only after 16 ticks, so an error in the phase reset or the terminal count shows only after hundreds of clocks. The bench therefore issues a write before every configuration and counts clocks from that write edge. It sweeps settings 0 to 5 over all four combinations of mode and speed, and it checks the first pulse and the spacing of the next pulses against the mode's divide ratio. In slave mode the pin is driven with every pair of high and low widths from 2 to 5 clocks while the internal divider ticks on every cycle. This shows that only the synchronized edges reach the strobes.

// File: rtl/usart_rate_gen.sv
module usart_rate_gen #(
  parameter int DIV_W       = 12,
  parameter int OVS_NORM    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_set,
  input  logic             div_wr,
  input  logic             dbl_speed,
  input  logic [1:0]       mode,
  input  logic             xck_in,
  output logic             xck_out,
  output logic             xck_oe,
  output logic             tx_bit_en,
  output logic             rx_samp_en
);
  localparam int PH_W = $clog2(OVS_NORM);
  localparam logic [PH_W-1:0] LAST_NORM = PH_W'(OVS_NORM - 1);
  localparam logic [PH_W-1:0] LAST_DBL  = PH_W'(OVS_NORM / 2 - 1);

  logic [DIV_W-1:0]       cnt_q;
  logic                   tick_q;
  logic [PH_W-1:0]        phase_q;
  logic                   xck_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  wire mode_async  = (mode == 2'b00);
  wire mode_master = (mode == 2'b01);
  wire mode_slave  = mode[1];
  wire dbl_eff     = dbl_speed & mode_async;
  wire [PH_W-1:0] ph_last = dbl_eff ? LAST_DBL : LAST_NORM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (div_wr) begin
      cnt_q  <= div_set;
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= div_set;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (div_wr || !mode_async)
      phase_q <= '0;
    else if (tick_q)
      phase_q <= (phase_q >= ph_last) ? '0 : PH_W'(phase_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      xck_q <= 1'b0;
    else if (div_wr || !mode_master)
      xck_q <= 1'b0;
    else if (tick_q)
      xck_q <= ~xck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], xck_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  wire ext_rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
  wire ext_fall  = ~sync_q[SYNC_STAGES-1] & prev_q;
  wire async_tx  = tick_q & (phase_q >= ph_last);

  assign rx_samp_en = mode_slave ? ext_rise : mode_master ? (tick_q & ~xck_q) : tick_q;
  assign tx_bit_en  = mode_slave ? ext_fall : mode_master ? (tick_q & xck_q)  : async_tx;
  assign xck_out    = xck_q;
  assign xck_oe     = mode_master;
endmodule

// File: rtl/usart_rate_gen_chk.sv
module usart_rate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       div_wr,
  input logic [1:0] mode,
  input logic       xck_in,
  input logic       xck_out,
  input logic       tx_bit_en,
  input logic       rx_samp_en
);
  // R2
  async_tx_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && tx_bit_en) |-> rx_samp_en);

  // R4
  master_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && rx_samp_en && !div_wr) |=> (xck_out || mode != 2'b01));

  // R4
  master_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && tx_bit_en) |=> !xck_out);

  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr && !mode[1]) |=> (!rx_samp_en && !tx_bit_en) || mode[1]);

  // R7
  slave_single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> $countones({rx_samp_en, tx_bit_en}) <= 1);

  // R7
  slave_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && rx_samp_en) |-> ($past(xck_in, 2) && !$past(xck_in, 3)));

  // R8
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> !xck_out);
endmodule

bind usart_rate_gen usart_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .mode(mode), .xck_in(xck_in),
  .xck_out(xck_out), .tx_bit_en(tx_bit_en), .rx_samp_en(rx_samp_en));

// File: tb/usart_rate_gen_bench.sv
module usart_rate_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div_set = '0;
  logic        div_wr = 1'b0;
  logic        dbl_speed = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        xck_in = 1'b0;
  logic        xck_out, xck_oe, tx_bit_en, rx_samp_en;

  int n_chk = 0;
  int n_bad = 0;

  usart_rate_gen u_usart_rate_gen (
    .clk(clk), .rst_n(rst_n), .div_set(div_set), .div_wr(div_wr),
    .dbl_speed(dbl_speed), .mode(mode), .xck_in(xck_in), .xck_out(xck_out),
    .xck_oe(xck_oe), .tx_bit_en(tx_bit_en), .rx_samp_en(rx_samp_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_cfg(input int s, input logic [1:0] md, input logic dbl);
    int rx_pos[3];
    int tx_pos[3];
    int nrx = 0;
    int ntx = 0;
    int p_rx, p_tx, f_tx, span;
    bit ds = dbl && (md == 2'b00);
    string tg;
    p_rx = (md == 2'b00) ? (s + 1) : 2 * (s + 1);
    p_tx = (md == 2'b00) ? (ds ? 8 : 16) * (s + 1) : 2 * (s + 1);
    f_tx = p_tx;
    tg = (md == 2'b01) ? (dbl ? "R5" : "R4") : (ds ? "R3" : "R2");
    span = 2 * p_tx + f_tx + 4;
    @(negedge clk);
    div_set = 12'(s); mode = md; dbl_speed = dbl; div_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    div_wr = 1'b0;
    chk(!rx_samp_en && !tx_bit_en, "R6 quiet after write", {30'd0, rx_samp_en, tx_bit_en}, 0);
    chk(xck_oe == (md == 2'b01), "R4 xck_oe", xck_oe, md == 2'b01);
    for (int c = 1; c <= span; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (rx_samp_en && nrx < 3) begin rx_pos[nrx] = c; nrx++; end
      if (tx_bit_en && ntx < 3) begin tx_pos[ntx] = c; ntx++; end
      if (md == 2'b01 && c == s + 2)
        chk(xck_out == 1'b1, "R4 xck_out raised", xck_out, 1);
    end
    chk(nrx == 3 && ntx == 3, {tg, " pulse count"}, nrx * 10 + ntx, 33);
    if (nrx == 3 && ntx == 3) begin
      chk(rx_pos[0] == s + 1, "R6 first rx", rx_pos[0], s + 1);
      chk(tx_pos[0] == f_tx, "R6 first tx", tx_pos[0], f_tx);
      chk(rx_pos[1] - rx_pos[0] == p_rx && rx_pos[2] - rx_pos[1] == p_rx,
          {tg, " rx period"}, rx_pos[2] - rx_pos[1], p_rx);
      chk(tx_pos[1] - tx_pos[0] == p_tx && tx_pos[2] - tx_pos[1] == p_tx,
          {tg, " tx period"}, tx_pos[2] - tx_pos[1], p_tx);
    end
  endtask

  task automatic slave_half(input logic lvl, input int len);
    int hits = 0;
    int other = 0;
    int where = 0;
    @(negedge clk);
    xck_in = lvl;
    for (int c = 1; c <= len; c++) begin
      @(posedge clk);
      @(negedge clk);
      if ((lvl ? rx_samp_en : tx_bit_en)) begin hits++; where = c; end
      if ((lvl ? tx_bit_en : rx_samp_en)) other++;
      if (xck_oe || xck_out) other++;
    end
    chk(hits == 1 && where == 2, lvl ? "R7 rise strobe" : "R7 fall strobe", where, 2);
    chk(other == 0, "R8 slave quiet", other, 0);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
      begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk(!rx_samp_en && !tx_bit_en && !xck_out, "R1 in reset",
            {29'd0, rx_samp_en, tx_bit_en, xck_out}, 0);
        rst_n = 1'b1;
        chk(!rx_samp_en && !tx_bit_en, "R1 before first tick",
            {30'd0, rx_samp_en, tx_bit_en}, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rx_samp_en == 1'b1, "R1 first tick after release", rx_samp_en, 1);

        for (int s = 0; s <= 5; s++) begin
          run_cfg(s, 2'b00, 1'b0);
          run_cfg(s, 2'b00, 1'b1);
          run_cfg(s, 2'b01, 1'b0);
          run_cfg(s, 2'b01, 1'b1);
        end

        @(negedge clk);
        div_set = 12'd0; mode = 2'b00; dbl_speed = 1'b0; div_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        div_wr = 1'b0;
        for (int c = 1; c <= 20; c++) begin
          @(posedge clk);
          @(negedge clk);
          chk(rx_samp_en == 1'b1, "R9 continuous sample", rx_samp_en, 1);
        end

        @(negedge clk);
        div_set = 12'd0; mode = 2'b10; xck_in = 1'b0; div_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        div_wr = 1'b0;
        repeat (4) @(negedge clk);
        for (int h = 2; h <= 5; h++)
          for (int l = 2; l <= 5; l++) begin
            slave_half(1'b1, h);
            slave_half(1'b0, l);
          end
        mode = 2'b11; dbl_speed = 1'b1;
        slave_half(1'b1, 3);
        slave_half(1'b0, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule